// File: doc/BRIEF.md
# Register Readback Output Multiplexer

This block holds a small bank of 10-bit control registers behind a synchronous write port with a 6-bit address. It can put any of them on the converter's 12-bit output bus in place of the live sample. One register, at address 62, controls readback. Its bit 9 turns readback on, and its bits 8..0 form a selector. The selector uses two levels. The top three bits choose between the control-register address space and a small space of calibration values that arrive on input ports. The low six bits address a control register, and they count only when the top three bits are zero.

With readback off, the registered output bus carries the converter sample. With readback on, the top ten bits of the bus carry the selected value and the two bottom bits are zero. The raw sample is always forwarded on a separate port to the calibration logic, so calibration keeps running during readback. Writing any value to address 63 raises a one-cycle clear pulse, and the pulse returns every register to zero.

Top module: `readback_mux`

## Requirements
- R1: A low `rst_n` at a rising edge clears every control register, the readback register and the output bus to zero.
- R2: With `wr_en` high at a rising edge, addresses 0..14 and 62 load `wr_data` at that edge. Writes to addresses 15..61 change nothing that can be read back.
- R3: While bit 9 of register 62 is 0, `dout` equals the `adc_in` value sampled at the previous rising edge.
- R4: While bit 9 of register 62 is 1, `dout[11:2]` carries the selected 10-bit value and `dout[1:0]` is 0.
- R5: When selector bits 8..6 are 000, selector bits 5..0 choose the value shown:
  - addresses 0..14 show the control register of that number;
  - address 62 shows the readback register itself;
  - address 63 and every address from 15 to 61 show zero.
- R6: When selector bits 8..6 are non-zero, selector bits 5..0 are ignored:
  - code 001 shows `cal_fine`;
  - code 010 shows `cal_coarse`;
  - code 011 shows `cal_avg`;
  - codes 100 to 111 show zero.
- R7: `cal_sample` always equals `adc_in` in the same cycle, whether readback is on or off.
- R8: A write to address 63 raises an internal clear pulse for the next cycle. The edge that ends that cycle clears all registers, and a write offered in that cycle is lost.
- R9: A write to register 62 that is made at one edge takes effect on `dout` at the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 6 | Register address |
| wr_data | input | 10 | Write data |
| adc_in | input | 12 | Converter sample |
| cal_fine | input | 10 | Fine-DAC calibration value |
| cal_coarse | input | 10 | Coarse-DAC calibration value |
| cal_avg | input | 10 | Averaged calibration value |
| dout | output | 12 | Registered output bus |
| cal_sample | output | 12 | Sample forwarded to calibration |

## Verification
The bench writes a distinct value to every address from 0 to 61 and then reads all 64 control selectors back. A decoder that aliased the sparse address space would show a register in place of zero. A decoder that forgot the self-view at address 62 would also be caught.

It sweeps all eight calibration codes with changing low selector bits. A design that let bits 5..0 take part would return a control register instead of a calibration input. A design that missed the unused codes would leak data.

The clear pulse is checked with a write made in the pulse cycle, which must be lost. Passthrough and the zeroed low bits are checked with nonzero samples, so a design that merged the bus instead of replacing the bits would be seen.

// File: rtl/rbk_pkg.sv
// Shared widths and addresses of the readback multiplexer.
package rbk_pkg;
    localparam int ADDR_W   = 6;              // register address width
    localparam int DATA_W   = 10;             // control register width
    localparam int BUS_W    = 12;             // converter bus width
    localparam int NUM_CTRL = 15;             // control registers at 0..NUM_CTRL-1
    localparam int ADDR_RB  = 62;             // readback control register
    localparam int ADDR_RST = 63;             // clear-pulse address
    localparam int SEL_W    = DATA_W - 1;     // selector width
    localparam int SPACE_W  = 3;              // selector space field width
    localparam int LOW_W    = BUS_W - DATA_W; // bus bits not covered by readback
    localparam logic [SPACE_W-1:0] SPC_CTRL   = 3'd0;
    localparam logic [SPACE_W-1:0] SPC_FINE   = 3'd1;
    localparam logic [SPACE_W-1:0] SPC_COARSE = 3'd2;
    localparam logic [SPACE_W-1:0] SPC_AVG    = 3'd3;
endpackage

// File: rtl/rbk_regbank.sv
// Control register bank with write port and clear pulse.
// Registers 0..NUM_CTRL-1 and RB_ADDR load on a write. Other addresses are
// dropped. A write to CLR_ADDR raises clr_q for one cycle; the next edge then
// zeroes every register, and that clear takes priority over a write.
// Assumes a synchronous active-low reset.
module rbk_regbank
    import rbk_pkg::*;
#(
    parameter int AW       = ADDR_W,
    parameter int DW       = DATA_W,
    parameter int NCTRL    = NUM_CTRL,
    parameter int RB_ADDR  = ADDR_RB,
    parameter int CLR_ADDR = ADDR_RST
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [AW-1:0]       wr_addr,
    input  logic [DW-1:0]       wr_data,
    output logic [NCTRL*DW-1:0] ctrl_flat,
    output logic [DW-1:0]       rb_q
);
    logic clr_q;

    // Clear pulse: set for the cycle after a write to CLR_ADDR.
    always_ff @(posedge clk) begin
        if (!rst_n) clr_q <= 1'b0;
        else        clr_q <= wr_en && (wr_addr == AW'(CLR_ADDR));
    end

    for (genvar i = 0; i < NCTRL; i++) begin : g_ctrl
        logic [DW-1:0] q;
        // One control register: cleared by reset or pulse, else loaded by write.
        always_ff @(posedge clk) begin
            if (!rst_n || clr_q)                      q <= '0;
            else if (wr_en && (wr_addr == AW'(i)))    q <= wr_data;
        end
        assign ctrl_flat[i*DW +: DW] = q;
    end

    // Readback control register.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_q)                          rb_q <= '0;
        else if (wr_en && (wr_addr == AW'(RB_ADDR)))  rb_q <= wr_data;
    end

    AST_SOFT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        clr_q |=> (rb_q == '0 && ctrl_flat == '0)); // R8
    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == AW'(0) && !clr_q) |=> (ctrl_flat[DW-1:0] == $past(wr_data))); // R2
endmodule

// File: rtl/rbk_select.sv
// Two-level readback selector, purely combinational.
// Selector space 000 takes the low bits as a control-register address.
// Spaces 001..011 pick a calibration input. Anything undefined gives zero.
module rbk_select
    import rbk_pkg::*;
#(
    parameter int AW      = ADDR_W,
    parameter int DW      = DATA_W,
    parameter int SW      = SEL_W,
    parameter int PW      = SPACE_W,
    parameter int NCTRL   = NUM_CTRL,
    parameter int RB_ADDR = ADDR_RB
) (
    input  logic [SW-1:0]       sel,
    input  logic [NCTRL*DW-1:0] ctrl_flat,
    input  logic [DW-1:0]       rb_q,
    input  logic [DW-1:0]       cal_fine,
    input  logic [DW-1:0]       cal_coarse,
    input  logic [DW-1:0]       cal_avg,
    output logic [DW-1:0]       sel_val
);
    logic [PW-1:0] space;
    logic [AW-1:0] idx;

    assign space = sel[SW-1 -: PW];
    assign idx   = sel[AW-1:0];

    // Choose the value by space first, then by control address.
    always_comb begin
        sel_val = '0;
        case (space)
            SPC_CTRL: begin
                for (int i = 0; i < NCTRL; i++)
                    if (idx == AW'(i)) sel_val = ctrl_flat[i*DW +: DW];
                if (idx == AW'(RB_ADDR)) sel_val = rb_q;
            end
            SPC_FINE:   sel_val = cal_fine;
            SPC_COARSE: sel_val = cal_coarse;
            SPC_AVG:    sel_val = cal_avg;
            default:    sel_val = '0;
        endcase
    end
endmodule

// File: rtl/rbk_outstage.sv
// Registered output bus.
// Passes the sample through, or replaces the top DW bits with the readback
// value and zeroes the rest. Assumes a synchronous active-low reset.
module rbk_outstage
    import rbk_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int BW = BUS_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rb_en,
    input  logic [DW-1:0] sel_val,
    input  logic [BW-1:0] adc_in,
    output logic [BW-1:0] dout
);
    localparam int LW = BW - DW;

    // Output register: readback value or converter sample.
    always_ff @(posedge clk) begin
        if (!rst_n)     dout <= '0;
        else if (rb_en) dout <= {sel_val, {LW{1'b0}}};
        else            dout <= adc_in;
    end

    AST_PASS_THRU: assert property (@(posedge clk) disable iff (!rst_n)
        !rb_en |=> (dout == $past(adc_in))); // R3
    AST_LOW_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rb_en |=> (dout[LW-1:0] == '0)); // R4
endmodule

// File: rtl/readback_mux.sv
// Top level of the register readback multiplexer.
// Holds the register bank, picks a readback value and drives the registered
// output bus. The raw sample always goes straight to cal_sample.
// Assumes a synchronous active-low reset and a single clock.
module readback_mux
    import rbk_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [BUS_W-1:0]  adc_in,
    input  logic [DATA_W-1:0] cal_fine,
    input  logic [DATA_W-1:0] cal_coarse,
    input  logic [DATA_W-1:0] cal_avg,
    output logic [BUS_W-1:0]  dout,
    output logic [BUS_W-1:0]  cal_sample
);
    logic [NUM_CTRL*DATA_W-1:0] ctrl_flat;
    logic [DATA_W-1:0]          rb_q;
    logic [DATA_W-1:0]          sel_val;
    logic                       rb_en;
    logic [SEL_W-1:0]           sel;

    assign rb_en      = rb_q[DATA_W-1];
    assign sel        = rb_q[SEL_W-1:0];
    assign cal_sample = adc_in;

    rbk_regbank i_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .ctrl_flat (ctrl_flat),
        .rb_q      (rb_q)
    );

    rbk_select i_sel (
        .sel        (sel),
        .ctrl_flat  (ctrl_flat),
        .rb_q       (rb_q),
        .cal_fine   (cal_fine),
        .cal_coarse (cal_coarse),
        .cal_avg    (cal_avg),
        .sel_val    (sel_val)
    );

    rbk_outstage i_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .rb_en   (rb_en),
        .sel_val (sel_val),
        .adc_in  (adc_in),
        .dout    (dout)
    );

    AST_CAL_UNUSED: assert property (@(posedge clk) disable iff (!rst_n)
        (rb_en && sel[SEL_W-1]) |=> (dout[BUS_W-1:LOW_W] == '0)); // R6
endmodule

// File: tb/test_readback_mux.sv
// Self-checking bench for readback_mux: sweeps the address and code spaces.
module test_readback_mux;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [5:0]  wr_addr = '0;
    logic [9:0]  wr_data = '0;
    logic [11:0] adc_in = '0;
    logic [9:0]  cal_fine = '0, cal_coarse = '0, cal_avg = '0;
    logic [11:0] dout, cal_sample;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    readback_mux i_readback_mux (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .adc_in(adc_in), .cal_fine(cal_fine),
        .cal_coarse(cal_coarse), .cal_avg(cal_avg), .dout(dout),
        .cal_sample(cal_sample)
    );

    function automatic logic [9:0] pat(int a);
        return 10'((a * 37 + 5) % 1024);
    endfunction

    task automatic check(string req, logic [11:0] act, logic [11:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Single-cycle write; returns at the falling edge after the write edge.
    task automatic wr(int a, logic [9:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 6'(a); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Enable readback of a selector, then sample one edge later (R9).
    task automatic view(logic [8:0] s);
        wr(62, {1'b1, s});
        @(negedge clk);
    endtask

    initial begin
        logic [11:0] exp;
        adc_in = 12'h5A7;
        repeat (3) @(negedge clk);
        check("R1 reset bus", dout, 12'h000);
        rst_n = 1'b1;
        @(negedge clk);
        check("R3 pass after reset", dout, 12'h5A7);
        view(9'd0);
        check("R1 gain cleared by reset", dout, 12'h000);
        view(9'd9);
        check("R1 polarity cleared by reset", dout, 12'h000);

        // R2: write every address except 62 and 63.
        for (int a = 0; a < 62; a++) wr(a, pat(a));
        adc_in = 12'hFFF;
        // R5: sweep the whole control address space.
        for (int s = 0; s < 64; s++) begin
            view(9'(s));
            if (s < 15)       exp = {pat(s), 2'b00};
            else if (s == 62) exp = {1'b1, 3'b000, 6'(s), 2'b00};
            else              exp = 12'h000;
            check((s < 15) ? "R2 R5 control read" : "R5 undefined or self", dout, exp);
            check("R4 low bits zero", {10'h0, dout[1:0]}, 12'h000);
        end

        // R6: calibration codes with changing low selector bits.
        cal_fine = 10'h2A5; cal_coarse = 10'h13C; cal_avg = 10'h3F1;
        for (int c = 1; c < 8; c++) begin
            for (int k = 0; k < 4; k++) begin
                view({3'(c), 6'((k * 21 + c) % 64)});
                case (c)
                    1: exp = {cal_fine, 2'b00};
                    2: exp = {cal_coarse, 2'b00};
                    3: exp = {cal_avg, 2'b00};
                    default: exp = 12'h000;
                endcase
                check("R6 cal space", dout, exp);
            end
        end

        // R7: the sample reaches cal_sample during readback.
        for (int v = 0; v < 16; v++) begin
            adc_in = 12'((v * 273 + 1) % 4096);
            #1;
            check("R7 cal sample in readback", cal_sample, adc_in);
        end

        // R3: disable readback and sweep the samples.
        wr(62, 10'h001);
        for (int v = 0; v < 32; v++) begin
            adc_in = 12'((v * 131 + 7) % 4096);
            #1;
            check("R7 cal sample", cal_sample, adc_in);
            @(negedge clk);
            check("R3 passthrough", dout, adc_in);
        end

        // R8: clear pulse; a write in the pulse cycle is lost.
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 6'd63; wr_data = 10'h3FF;
        @(negedge clk);
        wr_addr = 6'd0; wr_data = 10'h155;
        @(negedge clk);
        wr_en = 1'b0;
        @(negedge clk);
        check("R8 readback reg cleared, bus passes", dout, adc_in);
        view(9'd0);
        check("R8 write in pulse cycle lost", dout, 12'h000);
        view(9'd3);
        check("R8 wait A cleared", dout, 12'h000);
        view(9'd14);
        check("R8 DAC1 cleared", dout, 12'h000);

        // R9: a fresh write is visible exactly one edge later.
        wr(0, 10'h2C3);
        view(9'd0);
        check("R9 new value visible", dout, {10'h2C3, 2'b00});

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule